// File: doc/BRIEF.md
# Bundle Issue-Resource Allocator

The allocator takes a bundle of up to four decoded instructions, each a valid bit and a 5-bit class code, and decides whether the bundle can issue in one cycle. Each valid instruction must be given scalar issue slots (four slots, 0 to 3, with different class sets), and a vector class must also be given the vector pipes it needs. The six vector pipes are load, two multipliers, shift, cross-lane and store. Some classes need a fused pipe pair or all six pipes. Two memory classes need slots 0 and 1 together.

A depth-first search with backtracking runs over the candidate placements, one level per instruction, lowest index first. At each level it takes the first candidate that fits, so the answer is the first legal assignment in a fixed order. When no assignment exists, the block reports the first instruction at which the bundle prefix stops being placeable. Bundles enter through a valid/ready handshake. The registered result is held until the consumer takes it.

Top module: `bra_bundle_alloc`

## Requirements
- R1: `in_ready` is high only when no bundle is being searched and no result is pending. A bundle is taken at a rising edge with `in_valid` and `in_ready` both high. After the result is released, `in_ready` is high again from the next cycle.
- R2: Scalar class codes and the slots they accept (slot i is bit i of a lane's slot mask): 0 load and 1 store take slot 0 or 1. 2 ALU takes any slot. 3 memory-op, 4 new-value and 5 system take slot 0 only. 6 extended-ALU and 7 jump take slot 2 or 3. 8 jump-register takes slot 2. 9 control-register takes slot 3.
- R3: Pipe bits are 0 load, 1 multiplier A, 2 multiplier B, 3 shift, 4 cross-lane, 5 store. Single-pipe classes: 10 vector ALU (any slot, one of bits 1,2,3,4), 12 vector multiply (slot 2 or 3, bit 1 or 2), 15 permute (any slot, bit 4), 16 vector shift (any slot, bit 3).
- R4: Wide classes: 11 wide vector ALU (any slot, bits 1+2 or bits 3+4), 13 wide multiply (slot 2 or 3, bits 1+2), 14 wide multiply restricted to slot 2 (bits 1+2), 17 histogram (any slot, all six pipes).
- R5: Vector memory classes: 18 load (slot 0 or 1, bit 0 plus one of 1,2,3,4), 19 unaligned load (slots 0 and 1 together, bits 0+4), 20 store (slot 0, bit 5 plus one of 1,2,3,4), 21 unaligned store (slots 0 and 1, bits 5+4), 22 new-value store (slot 0, bit 5 only).
- R6: A bundle that has any legal assignment is reported legal (`out_legal`=1, `out_err`=0). No slot and no pipe goes to two instructions.
- R7: The chosen assignment is the first legal one when the candidates are ordered lane 0 first, and within a lane by lowest slot and then by lowest pipe set (the pipe orders listed in R3 to R5).
- R8: An illegal bundle gives `out_err`=1, `out_legal`=0, and `out_err_idx` = the smallest k such that lanes 0..k cannot all be placed. `out_placed`, `out_slot` and `out_pipe` are then all zero.
- R9: An invalid lane is never placed and gets no slot or pipe. A bundle with no valid lane is legal.
- R10: Codes 23 to 31 on a valid lane can never be placed.
- R11: While `out_valid` is high and `out_ready` is low, every result output holds its value.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| in_valid | input | 1 | bundle offered |
| in_ready | output | 1 | allocator can take a bundle |
| in_insn_vld | input | NUM_INSN | per-lane valid |
| in_insn_cls | input | NUM_INSN*5 | per-lane class code, lane i at bits 5i+4..5i |
| out_valid | output | 1 | result present |
| out_ready | input | 1 | consumer takes result |
| out_legal | output | 1 | bundle can issue |
| out_err | output | 1 | bundle cannot issue |
| out_err_idx | output | clog2(NUM_INSN) | first unplaceable lane |
| out_placed | output | NUM_INSN | lane received resources |
| out_slot | output | NUM_INSN*4 | per-lane slot mask |
| out_pipe | output | NUM_INSN*6 | per-lane pipe mask |

## Verification
The hardest case to reach is deep backtracking. An early lane has to give up its first-choice slot or pipe pair for a later lane, and an illegal bundle only fails after every prefix has been tried. Directed bundles produce these cases on purpose. Examples are an ALU op ahead of a slot-0-only op, two extended-ALU ops ahead of a jump-register, and three wide vector ALU ops fighting for two pipe pairs. Random bundles drawn mostly from the constrained classes then cover the rest, and each is compared with an exhaustive ordered search in the bench.

// File: rtl/bra_pkg.sv
package bra_pkg;
  localparam int SLOTS  = 4;
  localparam int PIPES  = 6;
  localparam int CODE_W = 5;
  localparam int OPT_W  = 4;
  localparam int OPTS   = 1 << OPT_W;

  localparam int PIPE_LD = 0;
  localparam int PIPE_MA = 1;
  localparam int PIPE_MB = 2;
  localparam int PIPE_SH = 3;
  localparam int PIPE_XL = 4;
  localparam int PIPE_ST = 5;

  localparam logic [PIPES-1:0] PM_LD   = PIPES'(1) << PIPE_LD;
  localparam logic [PIPES-1:0] PM_ST   = PIPES'(1) << PIPE_ST;
  localparam logic [PIPES-1:0] PM_SH   = PIPES'(1) << PIPE_SH;
  localparam logic [PIPES-1:0] PM_XL   = PIPES'(1) << PIPE_XL;
  localparam logic [PIPES-1:0] PM_MUL  = (PIPES'(1) << PIPE_MA) | (PIPES'(1) << PIPE_MB);
  localparam logic [PIPES-1:0] PM_SHXL = PM_SH | PM_XL;
  localparam logic [PIPES-1:0] PM_ANY4 = PM_MUL | PM_SHXL;
  localparam logic [PIPES-1:0] PM_ALL  = '1;

  typedef enum logic [CODE_W-1:0] {
    CL_LOAD    = 5'd0,  CL_STORE  = 5'd1,  CL_ALU    = 5'd2,  CL_MEMOP   = 5'd3,
    CL_NEWVAL  = 5'd4,  CL_SYSTEM = 5'd5,  CL_XTYPE  = 5'd6,  CL_JUMP    = 5'd7,
    CL_JUMPREG = 5'd8,  CL_CTLREG = 5'd9,  CL_VALU   = 5'd10, CL_VALU_W  = 5'd11,
    CL_VMPY    = 5'd12, CL_VMPY_W = 5'd13, CL_VMPY_W2 = 5'd14, CL_VPERM  = 5'd15,
    CL_VSHIFT  = 5'd16, CL_VHIST  = 5'd17, CL_VLD    = 5'd18, CL_VLDU    = 5'd19,
    CL_VST     = 5'd20, CL_VSTU   = 5'd21, CL_VST_NEW = 5'd22
  } cls_e;

  // Resource demand of one lane, as produced by the class decoder.
  typedef struct packed {
    logic             null_op;    // invalid lane: one empty candidate
    logic             slot_pair;  // needs slots 0 and 1 together
    logic [SLOTS-1:0] slot_one;   // choose exactly one of these slots
    logic [PIPES-1:0] pipe_base;  // always taken
    logic [PIPES-1:0] pipe_alt;   // choose exactly one of these as well
    logic             pipe_wide;  // choose multiplier pair or shift/cross-lane pair
  } req_t;

  typedef struct packed {
    logic             ok;
    logic [SLOTS-1:0] slots;
    logic [PIPES-1:0] pipes;
  } opt_t;
endpackage

// File: rtl/bra_class_decode.sv
module bra_class_decode
  import bra_pkg::*;
(
  input  logic              vld,
  input  logic [CODE_W-1:0] cls,
  output req_t              req
);
  always_comb begin
    req = '0;
    if (!vld) begin
      req.null_op = 1'b1;
    end else begin
      case (cls)
        CL_LOAD, CL_STORE:              req.slot_one = 4'b0011;
        CL_ALU:                         req.slot_one = 4'b1111;
        CL_MEMOP, CL_NEWVAL, CL_SYSTEM: req.slot_one = 4'b0001;
        CL_XTYPE, CL_JUMP:              req.slot_one = 4'b1100;
        CL_JUMPREG:                     req.slot_one = 4'b0100;
        CL_CTLREG:                      req.slot_one = 4'b1000;
        CL_VALU: begin
          req.slot_one = 4'b1111;
          req.pipe_alt = PM_ANY4;
        end
        CL_VALU_W: begin
          req.slot_one  = 4'b1111;
          req.pipe_wide = 1'b1;
        end
        CL_VMPY: begin
          req.slot_one = 4'b1100;
          req.pipe_alt = PM_MUL;
        end
        CL_VMPY_W: begin
          req.slot_one  = 4'b1100;
          req.pipe_base = PM_MUL;
        end
        CL_VMPY_W2: begin
          req.slot_one  = 4'b0100;
          req.pipe_base = PM_MUL;
        end
        CL_VPERM: begin
          req.slot_one  = 4'b1111;
          req.pipe_base = PM_XL;
        end
        CL_VSHIFT: begin
          req.slot_one  = 4'b1111;
          req.pipe_base = PM_SH;
        end
        CL_VHIST: begin
          req.slot_one  = 4'b1111;
          req.pipe_base = PM_ALL;
        end
        CL_VLD: begin
          req.slot_one  = 4'b0011;
          req.pipe_base = PM_LD;
          req.pipe_alt  = PM_ANY4;
        end
        CL_VLDU: begin
          req.slot_pair = 1'b1;
          req.pipe_base = PM_LD | PM_XL;
        end
        CL_VST: begin
          req.slot_one  = 4'b0001;
          req.pipe_base = PM_ST;
          req.pipe_alt  = PM_ANY4;
        end
        CL_VSTU: begin
          req.slot_pair = 1'b1;
          req.pipe_base = PM_ST | PM_XL;
        end
        CL_VST_NEW: begin
          req.slot_one  = 4'b0001;
          req.pipe_base = PM_ST;
        end
        default: req = '0;  // unknown code: no candidate at all
      endcase
    end
  end
endmodule

// File: rtl/bra_option_gen.sv
module bra_option_gen
  import bra_pkg::*;
(
  input  req_t             req,
  input  logic [OPT_W-1:0] idx,
  output opt_t             opt
);
  // Candidate index: upper half picks the slot choice, lower half the pipe choice.
  function automatic logic [SLOTS:0] nth_slot(input logic [SLOTS-1:0] v, input logic [1:0] n);
    logic [SLOTS:0] r;
    int cnt;
    r = '0;
    cnt = 0;
    for (int b = 0; b < SLOTS; b++) begin
      if (v[b]) begin
        if (cnt == int'(n)) begin
          r[SLOTS] = 1'b1;
          r[b]     = 1'b1;
        end
        cnt = cnt + 1;
      end
    end
    return r;
  endfunction

  function automatic logic [PIPES:0] nth_pipe(input logic [PIPES-1:0] v, input logic [1:0] n);
    logic [PIPES:0] r;
    int cnt;
    r = '0;
    cnt = 0;
    for (int b = 0; b < PIPES; b++) begin
      if (v[b]) begin
        if (cnt == int'(n)) begin
          r[PIPES] = 1'b1;
          r[b]     = 1'b1;
        end
        cnt = cnt + 1;
      end
    end
    return r;
  endfunction

  logic [1:0]       s_sel, p_sel;
  logic             s_ok, p_ok;
  logic [SLOTS-1:0] s_mask;
  logic [PIPES-1:0] p_mask;
  logic [SLOTS:0]   s_pick;
  logic [PIPES:0]   p_pick;

  assign s_sel  = idx[OPT_W-1:2];
  assign p_sel  = idx[1:0];
  assign s_pick = nth_slot(req.slot_one, s_sel);
  assign p_pick = nth_pipe(req.pipe_alt, p_sel);

  always_comb begin
    if (req.null_op) begin
      s_ok   = (s_sel == 2'd0);
      s_mask = '0;
    end else if (req.slot_pair) begin
      s_ok   = (s_sel == 2'd0);
      s_mask = 4'b0011;
    end else begin
      s_ok   = s_pick[SLOTS];
      s_mask = s_pick[SLOTS-1:0];
    end

    if (req.null_op) begin
      p_ok   = (p_sel == 2'd0);
      p_mask = '0;
    end else if (req.pipe_wide) begin
      p_ok   = (p_sel <= 2'd1);
      p_mask = (p_sel == 2'd0) ? PM_MUL : PM_SHXL;
    end else if (req.pipe_alt != '0) begin
      p_ok   = p_pick[PIPES];
      p_mask = req.pipe_base | p_pick[PIPES-1:0];
    end else begin
      p_ok   = (p_sel == 2'd0);
      p_mask = req.pipe_base;
    end

    opt.ok    = s_ok & p_ok;
    opt.slots = s_mask;
    opt.pipes = p_mask;
  end
endmodule

// File: rtl/bra_fit_scan.sv
module bra_fit_scan
  import bra_pkg::*;
(
  input  req_t             req,
  input  logic [OPT_W:0]   start,
  input  logic [SLOTS-1:0] used_slots,
  input  logic [PIPES-1:0] used_pipes,
  output logic             found,
  output logic [OPT_W-1:0] pick_idx,
  output opt_t             pick
);
  opt_t            cand [OPTS];
  logic [OPTS-1:0] fit;

  for (genvar g = 0; g < OPTS; g++) begin : g_cand
    bra_option_gen u_opt (
      .req (req),
      .idx (OPT_W'(g)),
      .opt (cand[g])
    );
    assign fit[g] = cand[g].ok
                  && ((OPT_W+1)'(g) >= start)
                  && ((cand[g].slots & used_slots) == '0)
                  && ((cand[g].pipes & used_pipes) == '0);
  end

  // Lowest-numbered fitting candidate wins.
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    pick     = '0;
    for (int g = OPTS - 1; g >= 0; g--) begin
      if (fit[g]) begin
        found    = 1'b1;
        pick_idx = OPT_W'(g);
        pick     = cand[g];
      end
    end
  end
endmodule

// File: rtl/bra_bundle_alloc.sv
module bra_bundle_alloc
  import bra_pkg::*;
#(
  parameter  int NUM_INSN = 4,
  localparam int IDX_W    = (NUM_INSN > 1) ? $clog2(NUM_INSN) : 1,
  localparam int LVL_W    = $clog2(NUM_INSN + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [NUM_INSN-1:0]       in_insn_vld,
  input  logic [NUM_INSN*CODE_W-1:0] in_insn_cls,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      out_legal,
  output logic                      out_err,
  output logic [IDX_W-1:0]          out_err_idx,
  output logic [NUM_INSN-1:0]       out_placed,
  output logic [NUM_INSN*SLOTS-1:0] out_slot,
  output logic [NUM_INSN*PIPES-1:0] out_pipe
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_e;

  st_e                     state;
  logic [LVL_W-1:0]        lvl, max_lvl;
  logic [NUM_INSN-1:0]     vld_q;
  logic [CODE_W-1:0]       cls_q    [NUM_INSN];
  logic [OPT_W:0]          start_q  [NUM_INSN];
  logic [OPT_W-1:0]        ch_idx   [NUM_INSN];
  logic [SLOTS-1:0]        ch_slots [NUM_INSN];
  logic [PIPES-1:0]        ch_pipes [NUM_INSN];

  req_t                    req_a [NUM_INSN];
  req_t                    cur_req;
  logic [OPT_W:0]          cur_start;
  logic [SLOTS-1:0]        used_slots;
  logic [PIPES-1:0]        used_pipes;
  logic                    found;
  logic [OPT_W-1:0]        pick_idx;
  opt_t                    pick;
  logic                    at_end;

  for (genvar i = 0; i < NUM_INSN; i++) begin : g_dec
    bra_class_decode u_dec (
      .vld (vld_q[i]),
      .cls (cls_q[i]),
      .req (req_a[i])
    );
  end

  // Demand of the lane at the current depth and resources held above it.
  always_comb begin
    cur_req    = '0;
    cur_start  = '0;
    used_slots = '0;
    used_pipes = '0;
    for (int i = 0; i < NUM_INSN; i++) begin
      if (lvl == LVL_W'(i)) begin
        cur_req   = req_a[i];
        cur_start = start_q[i];
      end
      if (LVL_W'(i) < lvl) begin
        used_slots = used_slots | ch_slots[i];
        used_pipes = used_pipes | ch_pipes[i];
      end
    end
  end

  assign at_end = (lvl == LVL_W'(NUM_INSN));

  bra_fit_scan u_scan (
    .req        (cur_req),
    .start      (cur_start),
    .used_slots (used_slots),
    .used_pipes (used_pipes),
    .found      (found),
    .pick_idx   (pick_idx),
    .pick       (pick)
  );

  assign in_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      lvl         <= '0;
      max_lvl     <= '0;
      vld_q       <= '0;
      out_valid   <= 1'b0;
      out_legal   <= 1'b0;
      out_err     <= 1'b0;
      out_err_idx <= '0;
      out_placed  <= '0;
      out_slot    <= '0;
      out_pipe    <= '0;
      for (int i = 0; i < NUM_INSN; i++) begin
        cls_q[i]    <= '0;
        start_q[i]  <= '0;
        ch_idx[i]   <= '0;
        ch_slots[i] <= '0;
        ch_pipes[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: begin
          if (in_valid) begin
            vld_q   <= in_insn_vld;
            lvl     <= '0;
            max_lvl <= '0;
            for (int i = 0; i < NUM_INSN; i++) begin
              cls_q[i]   <= in_insn_cls[i*CODE_W +: CODE_W];
              start_q[i] <= '0;
            end
            state <= S_RUN;
          end
        end
        S_RUN: begin
          if (at_end) begin
            out_valid   <= 1'b1;
            out_legal   <= 1'b1;
            out_err     <= 1'b0;
            out_err_idx <= '0;
            out_placed  <= vld_q;
            for (int i = 0; i < NUM_INSN; i++) begin
              out_slot[i*SLOTS +: SLOTS] <= ch_slots[i];
              out_pipe[i*PIPES +: PIPES] <= ch_pipes[i];
            end
            state <= S_DONE;
          end else if (found) begin
            for (int i = 0; i < NUM_INSN; i++) begin
              if (lvl == LVL_W'(i)) begin
                ch_idx[i]   <= pick_idx;
                ch_slots[i] <= pick.slots;
                ch_pipes[i] <= pick.pipes;
              end
            end
            for (int j = 1; j < NUM_INSN; j++) begin
              if (lvl == LVL_W'(j - 1)) start_q[j] <= '0;
            end
            lvl <= lvl + 1'b1;
            if (lvl + 1'b1 > max_lvl) max_lvl <= lvl + 1'b1;
          end else if (lvl == '0) begin
            out_valid   <= 1'b1;
            out_legal   <= 1'b0;
            out_err     <= 1'b1;
            out_err_idx <= IDX_W'(max_lvl);
            out_placed  <= '0;
            out_slot    <= '0;
            out_pipe    <= '0;
            state       <= S_DONE;
          end else begin
            // Backtrack: the lane above resumes after its last choice.
            for (int i = 0; i < NUM_INSN; i++) begin
              if (lvl == LVL_W'(i + 1)) start_q[i] <= {1'b0, ch_idx[i]} + 1'b1;
            end
            lvl <= lvl - 1'b1;
          end
        end
        S_DONE: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bra_alloc_chk.sv
module bra_alloc_chk
  import bra_pkg::*;
#(
  parameter  int NUM_INSN = 4,
  localparam int IDX_W    = (NUM_INSN > 1) ? $clog2(NUM_INSN) : 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic                      out_legal,
  input logic                      out_err,
  input logic [IDX_W-1:0]          out_err_idx,
  input logic [NUM_INSN-1:0]       out_placed,
  input logic [NUM_INSN*SLOTS-1:0] out_slot,
  input logic [NUM_INSN*PIPES-1:0] out_pipe
);
  int               slot_sum, pipe_sum;
  logic [SLOTS-1:0] slot_or;
  logic [PIPES-1:0] pipe_or;
  logic             lanes_ok;

  always_comb begin
    slot_sum = 0;
    pipe_sum = 0;
    slot_or  = '0;
    pipe_or  = '0;
    lanes_ok = 1'b1;
    for (int i = 0; i < NUM_INSN; i++) begin
      slot_sum = slot_sum + $countones(out_slot[i*SLOTS +: SLOTS]);
      pipe_sum = pipe_sum + $countones(out_pipe[i*PIPES +: PIPES]);
      slot_or  = slot_or | out_slot[i*SLOTS +: SLOTS];
      pipe_or  = pipe_or | out_pipe[i*PIPES +: PIPES];
      if (out_placed[i]) lanes_ok = lanes_ok && (out_slot[i*SLOTS +: SLOTS] != '0);
      else lanes_ok = lanes_ok && (out_slot[i*SLOTS +: SLOTS] == '0)
                               && (out_pipe[i*PIPES +: PIPES] == '0);
    end
  end

  assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_legal) && $stable(out_err)
      && $stable(out_err_idx) && $stable(out_placed) && $stable(out_slot) && $stable(out_pipe)));

  assert_verdict_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_legal != out_err));

  assert_disjoint_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_legal) |-> (slot_sum == $countones(slot_or) && pipe_sum == $countones(pipe_or)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_placed == '0 && out_slot == '0 && out_pipe == '0));

  assert_lanes_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_legal) |-> lanes_ok);

  assert_reset_R12: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));
endmodule

bind bra_bundle_alloc bra_alloc_chk #(.NUM_INSN(NUM_INSN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_legal   (out_legal),
  .out_err     (out_err),
  .out_err_idx (out_err_idx),
  .out_placed  (out_placed),
  .out_slot    (out_slot),
  .out_pipe    (out_pipe)
);

// File: tb/sim_bra_bundle_alloc.sv
module sim_bra_bundle_alloc;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [N-1:0] in_insn_vld = '0;
  logic [N*5-1:0] in_insn_cls = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic         out_legal, out_err;
  logic [1:0]   out_err_idx;
  logic [N-1:0] out_placed;
  logic [N*4-1:0] out_slot;
  logic [N*6-1:0] out_pipe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bra_bundle_alloc #(.NUM_INSN(N)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn_vld(in_insn_vld), .in_insn_cls(in_insn_cls),
    .out_valid(out_valid), .out_ready(out_ready), .out_legal(out_legal),
    .out_err(out_err), .out_err_idx(out_err_idx), .out_placed(out_placed),
    .out_slot(out_slot), .out_pipe(out_pipe)
  );

  // Reference candidate lists, ordered slot first then pipe set.
  int         ro_n [N];
  logic [3:0] ro_s [N][16];
  logic [5:0] ro_p [N][16];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic build(input int lane, input bit v, input int c);
    logic [3:0] sl [4];
    logic [5:0] pl [4];
    int ns, np, k;
    logic [3:0] smask;
    bit pair;
    ns = 0; np = 0; smask = 4'b0000; pair = 0;
    if (!v) begin
      ns = 1; sl[0] = 4'b0000; np = 1; pl[0] = 6'b0;
    end else begin
      np = 1; pl[0] = 6'b0;
      case (c)
        0, 1: smask = 4'b0011;
        2: smask = 4'b1111;
        3, 4, 5: smask = 4'b0001;
        6, 7: smask = 4'b1100;
        8: smask = 4'b0100;
        9: smask = 4'b1000;
        10: begin smask = 4'b1111; np = 4; pl[0] = 6'h02; pl[1] = 6'h04; pl[2] = 6'h08; pl[3] = 6'h10; end
        11: begin smask = 4'b1111; np = 2; pl[0] = 6'h06; pl[1] = 6'h18; end
        12: begin smask = 4'b1100; np = 2; pl[0] = 6'h02; pl[1] = 6'h04; end
        13: begin smask = 4'b1100; pl[0] = 6'h06; end
        14: begin smask = 4'b0100; pl[0] = 6'h06; end
        15: begin smask = 4'b1111; pl[0] = 6'h10; end
        16: begin smask = 4'b1111; pl[0] = 6'h08; end
        17: begin smask = 4'b1111; pl[0] = 6'h3f; end
        18: begin smask = 4'b0011; np = 4; pl[0] = 6'h03; pl[1] = 6'h05; pl[2] = 6'h09; pl[3] = 6'h11; end
        19: begin pair = 1; pl[0] = 6'h11; end
        20: begin smask = 4'b0001; np = 4; pl[0] = 6'h22; pl[1] = 6'h24; pl[2] = 6'h28; pl[3] = 6'h30; end
        21: begin pair = 1; pl[0] = 6'h30; end
        22: begin smask = 4'b0001; pl[0] = 6'h20; end
        default: np = 0;
      endcase
      if (pair) begin ns = 1; sl[0] = 4'b0011; end
      else for (int b = 0; b < 4; b++) if (smask[b]) begin sl[ns] = 4'(1 << b); ns++; end
    end
    k = 0;
    for (int s = 0; s < ns; s++)
      for (int p = 0; p < np; p++) begin
        ro_s[lane][k] = sl[s]; ro_p[lane][k] = pl[p]; k++;
      end
    ro_n[lane] = k;
  endtask

  // Ordered exhaustive search over lanes 0..lim; lanes above lim are ignored.
  task automatic ref_search(input int lim, output bit ok, output int pick [N]);
    int n [N];
    ok = 0;
    for (int l = 0; l < N; l++) begin n[l] = (l <= lim) ? ro_n[l] : 1; pick[l] = 0; end
    for (int a = 0; a < n[0] && !ok; a++) begin
      logic [3:0] s0; logic [5:0] p0;
      s0 = ro_s[0][a]; p0 = ro_p[0][a];
      for (int b = 0; b < n[1] && !ok; b++) begin
        logic [3:0] s1; logic [5:0] p1;
        s1 = (lim >= 1) ? ro_s[1][b] : 4'b0; p1 = (lim >= 1) ? ro_p[1][b] : 6'b0;
        if ((s1 & s0) != 0 || (p1 & p0) != 0) continue;
        for (int c = 0; c < n[2] && !ok; c++) begin
          logic [3:0] s2; logic [5:0] p2;
          s2 = (lim >= 2) ? ro_s[2][c] : 4'b0; p2 = (lim >= 2) ? ro_p[2][c] : 6'b0;
          if ((s2 & (s0 | s1)) != 0 || (p2 & (p0 | p1)) != 0) continue;
          for (int d = 0; d < n[3] && !ok; d++) begin
            logic [3:0] s3; logic [5:0] p3;
            s3 = (lim >= 3) ? ro_s[3][d] : 4'b0; p3 = (lim >= 3) ? ro_p[3][d] : 6'b0;
            if ((s3 & (s0 | s1 | s2)) != 0 || (p3 & (p0 | p1 | p2)) != 0) continue;
            ok = 1; pick[0] = a; pick[1] = b; pick[2] = c; pick[3] = d;
          end
        end
      end
    end
  endtask

  task automatic run_bundle(input logic [3:0] v, input int c0, input int c1,
                            input int c2, input int c3, input string tag, input bit hold);
    int cl [N];
    int pk [N];
    bit legal, okp;
    int eidx;
    logic [3:0] es; logic [5:0] ep;
    cl[0] = c0; cl[1] = c1; cl[2] = c2; cl[3] = c3;
    for (int l = 0; l < N; l++) build(l, v[l], cl[l]);
    ref_search(N - 1, legal, pk);
    eidx = 0;
    if (!legal)
      for (int k = N - 1; k >= 0; k--) begin
        int tmp [N];
        ref_search(k, okp, tmp);
        if (!okp) eidx = k;
      end

    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready idle", in_ready, 1);
    in_valid = 1'b1;
    in_insn_vld = v;
    for (int l = 0; l < N; l++) in_insn_cls[l*5 +: 5] = 5'(cl[l]);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R1", "in_ready busy", in_ready, 0);
    while (!out_valid) @(negedge clk);

    for (int rep = 0; rep < (hold ? 3 : 1); rep++) begin
      string t;
      t = (rep == 0) ? tag : "R11";
      check(out_legal == legal, t, "legal", out_legal, legal);
      check(out_err == !legal, t, "err", out_err, !legal);
      if (!legal) check(out_err_idx == 2'(eidx), t, "err_idx", out_err_idx, eidx);
      for (int l = 0; l < N; l++) begin
        es = legal ? ro_s[l][pk[l]] : 4'b0;
        ep = legal ? ro_p[l][pk[l]] : 6'b0;
        check(out_placed[l] == (legal && v[l]), t, $sformatf("placed%0d", l), out_placed[l], legal && v[l]);
        check(out_slot[l*4 +: 4] == es, t, $sformatf("slot%0d", l), out_slot[l*4 +: 4], es);
        check(out_pipe[l*6 +: 6] == ep, t, $sformatf("pipe%0d", l), out_pipe[l*6 +: 6], ep);
      end
      if (hold && rep < 2) @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R1", "out_valid released", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready back", in_ready, 1);
  endtask

  // Per-clock protocol model: a pending result always blocks new bundles.
  always @(negedge clk) begin
    if (!rst && !finished) check(!(out_valid && in_ready), "R1", "ready while pending", in_ready, 0);
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R12", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R12", "in_ready after reset", in_ready, 1);

    run_bundle(4'b1111, 2, 2, 2, 2, "R2", 1);
    run_bundle(4'b0111, 8, 6, 9, 0, "R2", 0);
    run_bundle(4'b0011, 2, 3, 0, 0, "R7", 0);      // ALU must move off slot 0
    run_bundle(4'b0111, 6, 6, 8, 0, "R8", 0);      // jump-register loses slot 2
    run_bundle(4'b0111, 0, 1, 3, 0, "R8", 0);
    run_bundle(4'b1111, 10, 10, 10, 10, "R3", 0);
    run_bundle(4'b0011, 15, 15, 0, 0, "R3", 0);
    run_bundle(4'b0111, 12, 12, 16, 0, "R3", 0);
    run_bundle(4'b0011, 11, 11, 0, 0, "R4", 0);
    run_bundle(4'b0111, 11, 11, 11, 0, "R4", 0);
    run_bundle(4'b0011, 17, 2, 0, 0, "R4", 0);
    run_bundle(4'b0011, 17, 10, 0, 0, "R4", 0);
    run_bundle(4'b0011, 14, 12, 0, 0, "R4", 0);
    run_bundle(4'b0011, 14, 6, 0, 0, "R4", 0);
    run_bundle(4'b0011, 13, 11, 0, 0, "R7", 0);
    run_bundle(4'b0011, 19, 0, 0, 0, "R5", 0);
    run_bundle(4'b0011, 19, 10, 0, 0, "R5", 0);
    run_bundle(4'b0011, 20, 22, 0, 0, "R5", 0);
    run_bundle(4'b0011, 21, 18, 0, 0, "R5", 0);
    run_bundle(4'b0011, 18, 20, 0, 0, "R5", 0);
    run_bundle(4'b0000, 3, 3, 3, 3, "R9", 0);
    run_bundle(4'b1010, 3, 3, 3, 3, "R9", 0);
    run_bundle(4'b0001, 23, 0, 0, 0, "R10", 0);
    run_bundle(4'b0011, 2, 31, 0, 0, "R10", 0);
    run_bundle(4'b1011, 2, 2, 31, 2, "R9", 0);

    for (int t = 0; t < 300; t++) begin
      logic [3:0] v;
      int c [4];
      for (int l = 0; l < 4; l++) begin
        v[l] = ($urandom_range(0, 9) < 8);
        c[l] = ($urandom_range(0, 19) == 0) ? $urandom_range(23, 31) : $urandom_range(0, 22);
      end
      run_bundle(v, c[0], c[1], c[2], c[3], "R6", (t % 25) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule